// File: doc/BRIEF.md
# Sprite Line Evaluation and Fetch Scheduler

This block chooses which sprites appear on the next scanline and then schedules the memory reads for their pattern rows. At the start of each line it walks a 64-entry sprite attribute table. It reads one entry per clock in ascending index order and keeps every entry whose vertical span covers the target line. The scan stops early when the display is narrow, because the scan is tied to the active part of the line. Only the first entries it keeps, up to a fetch budget, are accepted. The budget is the number of pattern-fetch slots left in horizontal blank. It depends on the dot rate, the programmed display width and whether memory accesses take one or two clocks. A per-line flag records any candidate that had to be dropped.

When background fetches stop, the line controller pulses a blank-start input. The block then issues one read request per accepted sprite, in selection order, over a valid/ready handshake. The selected-sprite list has two buffers. The list being built for the coming line lives in one bank, and the list published for the line being drawn lives in the other. The banks swap at each line start, so scanning never disturbs the list in use.

Top module: `sprite_line_sched`

## Requirements
- R1: After reset, shown_count is 0, shown_ovf is 0, shown_ids is all zeros, fetch_valid is 0 and attr_rd_en is 0.
- R2: The clock after line_start, the block starts reading attribute entries at address 0. It reads one entry per clock, each address one above the last, for exactly min(64, 2*hdw+3) reads.
- R3: attr_data holds y in bits 9:0, the pattern number in bits 19:10 and the height code in bits 21:20. Heights are 16 lines for code 0, 32 for code 1 and 64 for codes 2 and 3. An entry is a candidate when (next_line - y) mod 1024 is below its height. next_line is captured at line_start, and the attribute data arrives one clock after the read.
- R4: With two_clk at 0, the fetch budget is 2*max(0, C-3-hdw), capped at 16. C is 42, 56 or 85 character periods for dot_rate 0, 1 and 2 or 3.
- R5: With two_clk at 1, the fetch budget is max(0, C-3-hdw), capped at 16.
- R6: Candidates are accepted in ascending index order until the budget is used up. Any later candidate sets the overflow flag for that line. At the next line_start the accepted count, the overflow flag and the accepted indices are published. Slot k of shown_ids occupies bits 6k+5:6k, and unused slots read as zero.
- R7: A blank_start pulse starts one request per accepted sprite, in acceptance order. Each request carries fetch_addr = pattern*64 + row, where row is (next_line - y) mod 64, and fetch_sprite is the entry index. Each request stays valid with a stable address until fetch_ready. fetch_valid stays low when nothing was accepted, and it drops after the last request.
- R8: shown_count, shown_ovf and shown_ids change only at a line_start.
- R9: A line_start ends any fetch still outstanding: fetch_valid is 0 on the following clock.
- R10: At most 16 fetch handshakes complete between two line_start pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Pulse: new line begins; publish list, start scan |
| blank_start | input | 1 | Pulse: background fetches done; start pattern fetches |
| next_line | input | 10 | Line number that the scan targets |
| hdw | input | 7 | Display width in characters minus one |
| dot_rate | input | 2 | 0 slow, 1 medium, 2/3 fast |
| two_clk | input | 1 | 1 when each memory access takes two clocks |
| attr_rd_en | output | 1 | Attribute table read strobe |
| attr_addr | output | 6 | Attribute entry address |
| attr_data | input | 22 | Attribute entry, one clock after the read |
| fetch_valid | output | 1 | Pattern read request valid |
| fetch_ready | input | 1 | Pattern read request accepted |
| fetch_addr | output | 16 | Pattern number and row |
| fetch_sprite | output | 6 | Entry index of the sprite being fetched |
| shown_count | output | 5 | Sprites in the published list |
| shown_ovf | output | 1 | Candidates were dropped on the published line |
| shown_ids | output | 96 | Published entry indices, 6 bits per slot |

## Verification
The assertions check, on every clock, the handshake hold rule, the cut-off of fetches at line start, that the published list is frozen between line starts, that the read addresses step up by one, and the limits on reads, fetches and list length. Only the bench scenarios can show that the scan length and the fetch budget follow the width, dot-rate and access-mode arithmetic. The bench also shows that the candidate test wraps correctly at the top of the line range, and that the addresses fetched and the indices published match the sprites that should have been chosen.

// File: rtl/sle_pkg.sv
package sle_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'd0,
    RATE_MID  = 2'd1,
    RATE_FAST = 2'd2
  } dot_rate_e;

  // Character periods per whole line for each dot rate.
  function automatic int line_chars(input logic [1:0] rate);
    case (rate)
      RATE_SLOW: line_chars = 42;
      RATE_MID:  line_chars = 56;
      default:   line_chars = 85;
    endcase
  endfunction

  // Sprite height in lines for a 2-bit height code.
  function automatic int sprite_height(input logic [1:0] code);
    case (code)
      2'd0:    sprite_height = 16;
      2'd1:    sprite_height = 32;
      default: sprite_height = 64;
    endcase
  endfunction

endpackage

// File: rtl/sle_budget.sv
module sle_budget
  import sle_pkg::*;
#(
  parameter int N_ATTR  = 64,
  parameter int MAX_SPR = 16,
  parameter int HDW_W   = 7,
  parameter int LIM_W   = 7,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [HDW_W-1:0] hdw,
  input  logic [1:0]       rate,
  input  logic             two_clk,
  output logic [LIM_W-1:0] scan_lim,
  output logic [CNT_W-1:0] fetch_cap
);
  localparam int SW = HDW_W + 2;

  logic [SW-1:0]    span;
  logic [LIM_W-1:0] lim_n;
  logic [CNT_W-1:0] cap_n;
  int               slots;

  always_comb begin
    // scan window: two entries per displayed character plus one
    span  = {1'b0, hdw, 1'b0} + SW'(3);
    lim_n = (span > SW'(N_ATTR)) ? LIM_W'(N_ATTR) : LIM_W'(span);
    // fetch slots: blank characters left after display and overhead
    slots = line_chars(rate) - 3 - int'(hdw);
    if (slots < 0) slots = 0;
    if (!two_clk) slots = slots * 2;
    if (slots > MAX_SPR) slots = MAX_SPR;
    cap_n = CNT_W'(slots);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_lim  <= '0;
      fetch_cap <= '0;
    end else if (load) begin
      scan_lim  <= lim_n;
      fetch_cap <= cap_n;
    end
  end
endmodule

// File: rtl/sle_scan.sv
module sle_scan #(
  parameter int IDX_W = 6,
  parameter int LIM_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LIM_W-1:0] lim,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic             data_v,
  output logic [IDX_W-1:0] data_idx
);
  logic             active;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      idx      <= '0;
      data_v   <= 1'b0;
      data_idx <= '0;
    end else begin
      data_v   <= active && !start;
      data_idx <= idx;
      if (start) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active) begin
        if (LIM_W'(idx) == lim - LIM_W'(1)) active <= 1'b0;
        else idx <= idx + IDX_W'(1);
      end
    end
  end

  assign rd_en   = active;
  assign rd_addr = idx;
endmodule

// File: rtl/sle_select.sv
module sle_select
  import sle_pkg::*;
#(
  parameter int MAX_SPR = 16,
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 5,
  parameter int SLOT_W  = 4,
  parameter int Y_W     = 10,
  parameter int PAT_W   = 10,
  parameter int ROW_W   = 6,
  parameter int ATTR_W  = 22
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     swap,
  input  logic [Y_W-1:0]           next_line,
  input  logic                     data_v,
  input  logic [IDX_W-1:0]         data_idx,
  input  logic [ATTR_W-1:0]        attr_data,
  input  logic [CNT_W-1:0]         cap,
  input  logic [SLOT_W-1:0]        rd_ptr,
  output logic [CNT_W-1:0]         pend_cnt,
  output logic [IDX_W-1:0]         pend_idx,
  output logic [PAT_W-1:0]         pend_pat,
  output logic [ROW_W-1:0]         pend_row,
  output logic [CNT_W-1:0]         shown_cnt,
  output logic                     shown_ovf,
  output logic [MAX_SPR*IDX_W-1:0] shown_ids
);
  logic [Y_W-1:0]   target;
  logic             dbank;
  logic             ovf;
  logic [Y_W-1:0]   a_y, dy;
  logic [PAT_W-1:0] a_pat;
  logic [1:0]       a_code;
  logic             hit;

  logic [IDX_W-1:0] s_idx [2][MAX_SPR];
  logic [PAT_W-1:0] s_pat [2][MAX_SPR];
  logic [ROW_W-1:0] s_row [2][MAX_SPR];

  always_comb begin
    a_y    = attr_data[Y_W-1:0];
    a_pat  = attr_data[Y_W +: PAT_W];
    a_code = attr_data[Y_W+PAT_W +: 2];
    dy     = target - a_y;
    hit    = data_v && (dy < Y_W'(sprite_height(a_code)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      target    <= '0;
      dbank     <= 1'b0;
      pend_cnt  <= '0;
      ovf       <= 1'b0;
      shown_cnt <= '0;
      shown_ovf <= 1'b0;
    end else if (swap) begin
      target    <= next_line;
      dbank     <= ~dbank;
      shown_cnt <= pend_cnt;
      shown_ovf <= ovf;
      pend_cnt  <= '0;
      ovf       <= 1'b0;
    end else if (hit) begin
      if (pend_cnt < cap) pend_cnt <= pend_cnt + CNT_W'(1);
      else ovf <= 1'b1;
    end
  end

  // list storage: no reset, written one slot per accepted candidate
  always_ff @(posedge clk) begin
    if (!rst && !swap && hit && (pend_cnt < cap)) begin
      s_idx[~dbank][pend_cnt[SLOT_W-1:0]] <= data_idx;
      s_pat[~dbank][pend_cnt[SLOT_W-1:0]] <= a_pat;
      s_row[~dbank][pend_cnt[SLOT_W-1:0]] <= dy[ROW_W-1:0];
    end
  end

  assign pend_idx = s_idx[~dbank][rd_ptr];
  assign pend_pat = s_pat[~dbank][rd_ptr];
  assign pend_row = s_row[~dbank][rd_ptr];

  for (genvar k = 0; k < MAX_SPR; k++) begin : g_slot
    assign shown_ids[k*IDX_W +: IDX_W] =
      (CNT_W'(k) < shown_cnt) ? s_idx[dbank][k] : '0;
  end
endmodule

// File: rtl/sle_fetch.sv
module sle_fetch #(
  parameter int CNT_W  = 5,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              abort,
  input  logic [CNT_W-1:0]  count,
  input  logic              ready,
  output logic              valid,
  output logic [SLOT_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      ptr   <= '0;
    end else if (abort) begin
      valid <= 1'b0;
    end else if (go) begin
      ptr   <= '0;
      valid <= (count != '0);
    end else if (valid && ready) begin
      if (CNT_W'(ptr) == count - CNT_W'(1)) valid <= 1'b0;
      else ptr <= ptr + SLOT_W'(1);
    end
  end
endmodule

// File: rtl/sprite_line_sched.sv
module sprite_line_sched
  import sle_pkg::*;
#(
  parameter int N_ATTR  = 64,
  parameter int MAX_SPR = 16,
  parameter int Y_W     = 10,
  parameter int PAT_W   = 10,
  parameter int ROW_W   = 6,
  parameter int HDW_W   = 7
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   line_start,
  input  logic                                   blank_start,
  input  logic [Y_W-1:0]                         next_line,
  input  logic [HDW_W-1:0]                       hdw,
  input  logic [1:0]                             dot_rate,
  input  logic                                   two_clk,
  output logic                                   attr_rd_en,
  output logic [$clog2(N_ATTR)-1:0]              attr_addr,
  input  logic [Y_W+PAT_W+1:0]                   attr_data,
  output logic                                   fetch_valid,
  input  logic                                   fetch_ready,
  output logic [PAT_W+ROW_W-1:0]                 fetch_addr,
  output logic [$clog2(N_ATTR)-1:0]              fetch_sprite,
  output logic [$clog2(MAX_SPR+1)-1:0]           shown_count,
  output logic                                   shown_ovf,
  output logic [MAX_SPR*$clog2(N_ATTR)-1:0]      shown_ids
);
  localparam int IDX_W  = $clog2(N_ATTR);
  localparam int CNT_W  = $clog2(MAX_SPR + 1);
  localparam int SLOT_W = $clog2(MAX_SPR);
  localparam int LIM_W  = $clog2(N_ATTR + 1);
  localparam int ATTR_W = Y_W + PAT_W + 2;

  logic [LIM_W-1:0]  scan_lim;
  logic [CNT_W-1:0]  fetch_cap;
  logic              data_v;
  logic [IDX_W-1:0]  data_idx;
  logic [CNT_W-1:0]  pend_cnt;
  logic [SLOT_W-1:0] rd_ptr;
  logic [PAT_W-1:0]  pend_pat;
  logic [ROW_W-1:0]  pend_row;

  sle_budget #(
    .N_ATTR(N_ATTR), .MAX_SPR(MAX_SPR), .HDW_W(HDW_W),
    .LIM_W(LIM_W), .CNT_W(CNT_W)
  ) u_budget (
    .clk(clk), .rst(rst), .load(line_start), .hdw(hdw),
    .rate(dot_rate), .two_clk(two_clk),
    .scan_lim(scan_lim), .fetch_cap(fetch_cap)
  );

  sle_scan #(.IDX_W(IDX_W), .LIM_W(LIM_W)) u_scan (
    .clk(clk), .rst(rst), .start(line_start), .lim(scan_lim),
    .rd_en(attr_rd_en), .rd_addr(attr_addr),
    .data_v(data_v), .data_idx(data_idx)
  );

  sle_select #(
    .MAX_SPR(MAX_SPR), .IDX_W(IDX_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W),
    .Y_W(Y_W), .PAT_W(PAT_W), .ROW_W(ROW_W), .ATTR_W(ATTR_W)
  ) u_select (
    .clk(clk), .rst(rst), .swap(line_start), .next_line(next_line),
    .data_v(data_v), .data_idx(data_idx), .attr_data(attr_data),
    .cap(fetch_cap), .rd_ptr(rd_ptr), .pend_cnt(pend_cnt),
    .pend_idx(fetch_sprite), .pend_pat(pend_pat), .pend_row(pend_row),
    .shown_cnt(shown_count), .shown_ovf(shown_ovf), .shown_ids(shown_ids)
  );

  sle_fetch #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_fetch (
    .clk(clk), .rst(rst), .go(blank_start), .abort(line_start),
    .count(pend_cnt), .ready(fetch_ready),
    .valid(fetch_valid), .ptr(rd_ptr)
  );

  assign fetch_addr = {pend_pat, pend_row};
endmodule

// File: rtl/sle_checker.sv
module sle_checker #(
  parameter int N_ATTR  = 64,
  parameter int MAX_SPR = 16,
  parameter int FA_W    = 16
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  line_start,
  input logic                                  attr_rd_en,
  input logic [$clog2(N_ATTR)-1:0]             attr_addr,
  input logic                                  fetch_valid,
  input logic                                  fetch_ready,
  input logic [FA_W-1:0]                       fetch_addr,
  input logic [$clog2(MAX_SPR+1)-1:0]          shown_count,
  input logic                                  shown_ovf,
  input logic [MAX_SPR*$clog2(N_ATTR)-1:0]     shown_ids
);
  logic [7:0] n_fetch, n_read;

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      n_fetch <= '0;
      n_read  <= '0;
    end else begin
      if (fetch_valid && fetch_ready) n_fetch <= n_fetch + 8'd1;
      if (attr_rd_en) n_read <= n_read + 8'd1;
    end
  end

  p_fetch_limit_r10: assert property (@(posedge clk) disable iff (rst)
    n_fetch <= 8'(MAX_SPR));

  p_scan_span_r2: assert property (@(posedge clk) disable iff (rst)
    n_read <= 8'(N_ATTR));

  p_scan_step_r2: assert property (@(posedge clk) disable iff (rst)
    attr_rd_en && $past(attr_rd_en) && !$past(line_start) |->
      attr_addr == $past(attr_addr) + 1'b1);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    fetch_valid && !fetch_ready && !line_start |=>
      fetch_valid && $stable(fetch_addr));

  p_cut_off_r9: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !fetch_valid);

  p_list_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(shown_count) && $stable(shown_ovf) && $stable(shown_ids));

  p_list_len_r6: assert property (@(posedge clk) disable iff (rst)
    shown_count <= MAX_SPR);
endmodule

bind sprite_line_sched sle_checker #(
  .N_ATTR(N_ATTR), .MAX_SPR(MAX_SPR), .FA_W(PAT_W + ROW_W)
) u_sle_chk (
  .clk(clk), .rst(rst), .line_start(line_start),
  .attr_rd_en(attr_rd_en), .attr_addr(attr_addr),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .fetch_addr(fetch_addr), .shown_count(shown_count),
  .shown_ovf(shown_ovf), .shown_ids(shown_ids)
);

// File: tb/test_sprite_line_sched.sv
module test_sprite_line_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_start = 1'b0, blank_start = 1'b0;
  logic [9:0]  next_line = '0;
  logic [6:0]  hdw = '0;
  logic [1:0]  dot_rate = '0;
  logic        two_clk = 1'b0;
  logic        attr_rd_en;
  logic [5:0]  attr_addr;
  logic [21:0] attr_data = '0;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [15:0] fetch_addr;
  logic [5:0]  fetch_sprite;
  logic [4:0]  shown_count;
  logic        shown_ovf;
  logic [95:0] shown_ids;

  always #5 clk = ~clk;

  sprite_line_sched i_sprite_line_sched (.*);

  logic [21:0] tbl [64];
  always @(posedge clk) if (attr_rd_en) attr_data <= tbl[attr_addr];

  int n_total = 0, n_fail = 0;
  int exp_cnt, exp_lim, exp_cap;
  bit exp_ovf;
  int exp_ids [16];
  int exp_addr [16];
  int prev_cnt = 0;
  bit prev_ovf = 0;
  logic [95:0] prev_vec = '0;
  bit prev_stall = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int budget(input int rate, input int w, input bit two);
    int t = (rate == 0) ? 42 : (rate == 1) ? 56 : 85;
    int b = t - 3 - w;
    if (b < 0) b = 0;
    if (!two) b = b * 2;
    if (b > 16) b = 16;
    return b;
  endfunction

  task automatic expect_line(input int nl, input int w, input int rate, input bit two);
    exp_lim = (2 * w + 3 > 64) ? 64 : 2 * w + 3;
    exp_cap = budget(rate, w, two);
    exp_cnt = 0;
    exp_ovf = 0;
    for (int e = 0; e < exp_lim; e++) begin
      int y = int'(tbl[e][9:0]);
      int p = int'(tbl[e][19:10]);
      int c = int'(tbl[e][21:20]);
      int dy = (nl - y) & 1023;
      int h = (c == 0) ? 16 : (c == 1) ? 32 : 64;
      if (dy < h) begin
        if (exp_cnt < exp_cap) begin
          exp_ids[exp_cnt] = e;
          exp_addr[exp_cnt] = p * 64 + (dy % 64);
          exp_cnt++;
        end else exp_ovf = 1;
      end
    end
  endtask

  task automatic run_line(input int nl, input int w, input int rate,
                          input bit two, input bit stall);
    int nreads = 0;
    bit order_ok = 1;
    int k = 0;
    logic [95:0] vec = '0;
    expect_line(nl, w, rate, two);
    @(negedge clk);
    next_line = 10'(nl); hdw = 7'(w); dot_rate = 2'(rate); two_clk = two;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    // R8 / R6: previous line's selection published at this line start
    check(shown_count == 5'(prev_cnt), "R8", "published count", shown_count, prev_cnt);
    check(shown_ovf == prev_ovf, "R6", "overflow flag", shown_ovf, prev_ovf);
    check(shown_ids == prev_vec, "R6", "published index list", shown_ids, prev_vec);
    if (prev_stall)
      check(fetch_valid == 1'b0, "R9", "fetch cut off by line start", fetch_valid, 0);
    for (int c = 0; c < 80; c++) begin
      if (attr_rd_en) begin
        if (int'(attr_addr) != nreads) order_ok = 0;
        nreads++;
      end
      @(negedge clk);
    end
    check(nreads == exp_lim, "R2", "entries scanned", nreads, exp_lim);
    check(order_ok, "R2", "ascending scan order", order_ok, 1);
    check(shown_count == 5'(prev_cnt), "R8", "list held during scan", shown_count, prev_cnt);
    blank_start = 1'b1;
    @(negedge clk);
    blank_start = 1'b0;
    if (stall) begin
      repeat (12) @(negedge clk);
      check(fetch_valid == (exp_cnt != 0), "R7", "request held while not ready",
            fetch_valid, exp_cnt != 0);
      if (exp_cnt != 0)
        check(fetch_addr == 16'(exp_addr[0]), "R7", "held address", fetch_addr, exp_addr[0]);
    end else begin
      for (int c = 0; c < 400 && k < exp_cnt; c++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        fetch_ready = lf[0] | lf[3];
        if (fetch_valid && fetch_ready) begin
          check(fetch_addr == 16'(exp_addr[k]), (two ? "R5" : "R4"), "fetch address",
                fetch_addr, exp_addr[k]);
          check(fetch_sprite == 6'(exp_ids[k]), "R3", "fetched entry", fetch_sprite, exp_ids[k]);
          k++;
        end
        @(negedge clk);
      end
      fetch_ready = 1'b0;
      check(k == exp_cnt, (two ? "R5" : "R4"), "fetch count vs budget", k, exp_cnt);
      @(negedge clk);
      check(fetch_valid == 1'b0, "R7", "no request beyond list", fetch_valid, 0);
    end
    for (int s = 0; s < exp_cnt; s++) vec[s*6 +: 6] = 6'(exp_ids[s]);
    prev_cnt = exp_cnt;
    prev_ovf = exp_ovf;
    prev_vec = vec;
    prev_stall = stall && (exp_cnt != 0);
  endtask

  initial begin
    #1_990_000;
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    for (int e = 0; e < 64; e++) tbl[e] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(shown_count == 0 && shown_ovf == 0 && shown_ids == '0, "R1", "list reset",
          shown_count, 0);
    check(fetch_valid == 0 && attr_rd_en == 0, "R1", "idle strobes", fetch_valid, 0);

    // Sweep: every entry is a candidate, so the budget and window limit the list.
    for (int e = 0; e < 64; e++) tbl[e] = {2'd0, 10'(e + 100), 10'(50 - (e % 10))};
    for (int rate = 0; rate < 3; rate++)
      for (int two = 0; two < 2; two++) begin
        run_line(50, 0, rate, two[0], 0);
        run_line(50, 127, rate, two[0], 0);
        for (int w = 'h1C; w <= 'h46; w++) run_line(50, w, rate, two[0], 0);
      end

    // R3: sparse tables with mixed heights, including wrap at the top of the range.
    for (int e = 0; e < 64; e++) tbl[e] = {2'(e % 4), 10'(e * 7 + 1), 10'((e * 9) % 1024)};
    run_line(200, 'h27, 1, 0, 0);
    run_line(0, 'h27, 1, 0, 0);
    run_line(5, 'h1F, 0, 0, 0);
    run_line(560, 'h2B, 2, 1, 0);
    for (int e = 0; e < 64; e++) tbl[e] = {2'(e % 3), 10'(e * 3), 10'((1000 + e * 2) % 1024)};
    run_line(10, 'h27, 1, 0, 0);
    run_line(1020, 'h1D, 0, 0, 0);
    // R9: fetches stalled then cut off by the next line start
    run_line(30, 'h27, 1, 1, 1);
    run_line(1023, 'h3F, 2, 1, 0);
    run_line(40, 'h27, 1, 0, 0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule